// File: doc/BRIEF.md
# Page Table Walker for 32-bit Linear Addresses

The walker turns a 32-bit linear address into a physical address. It reads a tree of translation tables held in memory, one entry per read, over a plain request/response port. A single input picks between two table formats. The compact format uses 4-byte entries and a two-level tree indexed 10/10 above a 12-bit page offset. Its top level can also map a 4 MB region directly. The wide format uses 8-byte entries and a three-level tree indexed 2/9/9 above the offset. It produces a 36-bit physical address, can map a 2 MB region at its middle level, and honours a per-page execute-disable flag.

A client presents a linear address and an access kind together with a one-cycle request strobe. While the walk runs, `busy` is high. The walk ends with a one-cycle `done` pulse. At that point `paddr` holds the translation, or `fault` is set together with a cause code and the tree level where the walk stopped. Translations are not cached, and table entries are never written back.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req_valid` are low and `paddr` is zero.
- R2: Compact mode (`ext_mode`=0), 4 KB page: the first read is at {root_base[35:12], va[31:22], 2'b00}. The second read is at {E0[31:12], va[21:12], 2'b00}. The result is {4'h0, E1[31:12], va[11:0]}. In every entry, bit 0 means present, bit 1 means writable and bit 7 means large mapping.
- R3: Compact mode: a present top entry with bit 7 set ends the walk after one read. The result is {4'h0, E0[31:22], va[21:0]}.
- R4: Wide mode (`ext_mode`=1): the reads are at {root_base[35:5], va[31:30], 3'b000}, then {E0[35:12], va[29:21], 3'b000}, then {E1[35:12], va[20:12], 3'b000}. The result is {E2[35:12], va[11:0]}. Bit 7 of the top entry has no effect.
- R5: Wide mode: a present middle entry with bit 7 set ends the walk after two reads. The result is {E1[35:21], va[20:0]}.
- R6: An entry with bit 0 clear ends the walk at once with `fault`=1 and `fault_code`=1. `fault_level` gives the level of that entry: 0 for the top, 1 for the next, 2 for the third. No further read is issued.
- R7: Access kinds are `req_acc` 0 = read, 1 = write, 2 = fetch. A write faults with `fault_code`=2 when bit 1 is clear in any entry on the path. `fault_level` is then the level of the final entry. Reads and fetches ignore bit 1.
- R8: In wide mode, a fetch faults with `fault_code`=3 when bit 63 is set in any entry on the path. In compact mode, bit 63 and the other upper bits have no effect.
- R9: Only one walk runs at a time. `busy` rises the cycle after an accepted request and stays high until the `done` cycle. A request strobe while busy is ignored. `done` lasts one cycle. At most one read is outstanding, and each `mem_req_valid` lasts one cycle.
- R10: `paddr`, `fault`, `fault_code` and `fault_level` change only in the cycle in which `done` is high, and they hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 0 = compact two-level format, 1 = wide three-level format; sampled on request |
| root_base | input | 36 | Physical base address of the top table |
| req_valid | input | 1 | One-cycle translate request strobe |
| req_vaddr | input | 32 | Linear address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read; compact mode uses bits 31:0 |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | The finished walk faulted |
| fault_code | output | 2 | 1 not present, 2 write denied, 3 execute denied |
| fault_level | output | 2 | Tree level of the entry that ended the walk |
| paddr | output | 36 | Translated physical address |

## Verification
The hardest state to reach is a second request strobe arriving in the middle of a walk. The bench reaches it by stretching the memory response latency to several cycles, then pulsing a request with a different address and mode while the first walk is still waiting on memory. The ignored strobe is exposed at the ports in three ways: the result still matches the first walk, the read count stays at the first walk's depth, and no read appears after `done`. Permission faults that come from an upper entry rather than the leaf are produced by clearing the write bit, or setting the execute-disable bit, only in the top or middle entry.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 36;
    localparam int ENT_W   = 64;
    localparam int PG_SH   = 12;
    localparam int LVL_W   = 2;
    localparam int B_PRES  = 0;
    localparam int B_WR    = 1;
    localparam int B_BIG   = 7;
    localparam int B_NX    = 63;

    typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
    typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_WRPROT = 2'd2, FLT_NOEXEC = 2'd3} flt_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

    typedef struct packed {
        st_e              st;
        logic [LVL_W-1:0] lvl;
        logic             ext;
        logic [1:0]       acc;
        logic [VA_W-1:0]  va;
        logic [PA_W-1:0]  base;
        logic             wr_ok;
        logic             nx;
        logic             fault;
        logic [1:0]       code;
        logic [LVL_W-1:0] flvl;
        logic [PA_W-1:0]  pa;
    } walk_t;
endpackage

// File: rtl/xlate_entry_addr.sv
module xlate_entry_addr
    import xlate_pkg::*;
(
    input  logic             ext,
    input  logic [LVL_W-1:0] lvl,
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  va,
    output logic [PA_W-1:0]  addr
);
    localparam int NIDX_W = 10;
    localparam int WIDX_W = 9;

    logic [NIDX_W-1:0] n_idx;
    logic [WIDX_W-1:0] w_idx;
    logic              unused_base;

    assign unused_base = ^base[4:0];

    always_comb begin
        n_idx = (lvl == '0) ? va[31:22] : va[21:12];
        w_idx = (lvl == 2'd1) ? va[29:21] : va[20:12];
        if (!ext)
            addr = {base[PA_W-1:PG_SH], n_idx, 2'b00};
        else if (lvl == '0)
            addr = {base[PA_W-1:5], va[31:30], 3'b000};
        else
            addr = {base[PA_W-1:PG_SH], w_idx, 3'b000};
    end
endmodule

// File: rtl/xlate_entry_decode.sv
module xlate_entry_decode
    import xlate_pkg::*;
(
    input  logic             ext,
    input  logic [LVL_W-1:0] lvl,
    input  logic [ENT_W-1:0] ent,
    output logic             present,
    output logic             wr,
    output logic             nx,
    output logic             big,
    output logic             leaf,
    output logic [PA_W-1:0]  next_base
);
    logic unused_bits;
    assign unused_bits = ^{ent[62:36], ent[6:2], ent[11:8]};

    always_comb begin
        present   = ent[B_PRES];
        wr        = ent[B_WR];
        nx        = ext & ent[B_NX];
        big       = ent[B_BIG] & (ext ? (lvl == 2'd1) : (lvl == 2'd0));
        leaf      = big | (ext ? (lvl == 2'd2) : (lvl == 2'd1));
        next_base = ext ? {ent[35:PG_SH], {PG_SH{1'b0}}}
                        : {4'h0, ent[31:PG_SH], {PG_SH{1'b0}}};
    end
endmodule

// File: rtl/xlate_leaf_pa.sv
module xlate_leaf_pa
    import xlate_pkg::*;
(
    input  logic             ext,
    input  logic             big,
    input  logic [ENT_W-1:0] ent,
    input  logic [VA_W-1:0]  va,
    output logic [PA_W-1:0]  pa
);
    logic unused_va;
    assign unused_va = ^{va[31:22], ent[63:36], ent[11:0]};

    always_comb begin
        unique case ({ext, big})
            2'b00:   pa = {4'h0, ent[31:PG_SH], va[PG_SH-1:0]};
            2'b01:   pa = {4'h0, ent[31:22], va[21:0]};
            2'b10:   pa = {ent[35:PG_SH], va[PG_SH-1:0]};
            default: pa = {ent[35:21], va[20:0]};
        endcase
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic [PA_W-1:0]  root_base,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    output logic             busy,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [1:0]       fault_code,
    output logic [LVL_W-1:0] fault_level,
    output logic [PA_W-1:0]  paddr
);
    localparam walk_t RST = '{st: ST_IDLE, default: '0};

    walk_t q, d;

    logic            e_pres, e_wr, e_nx, e_big, e_leaf;
    logic [PA_W-1:0] e_next, leaf_pa;
    logic            wr_path, nx_path;

    xlate_entry_addr u_addr (
        .ext  (q.ext),
        .lvl  (q.lvl),
        .base (q.base),
        .va   (q.va),
        .addr (mem_req_addr)
    );

    xlate_entry_decode u_dec (
        .ext       (q.ext),
        .lvl       (q.lvl),
        .ent       (mem_rsp_data),
        .present   (e_pres),
        .wr        (e_wr),
        .nx        (e_nx),
        .big       (e_big),
        .leaf      (e_leaf),
        .next_base (e_next)
    );

    xlate_leaf_pa u_pa (
        .ext (q.ext),
        .big (e_big),
        .ent (mem_rsp_data),
        .va  (q.va),
        .pa  (leaf_pa)
    );

    assign wr_path = q.wr_ok & e_wr;
    assign nx_path = q.nx | e_nx;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_ISSUE;
                    d.ext   = ext_mode;
                    d.va    = req_vaddr;
                    d.acc   = req_acc;
                    d.base  = root_base;
                    d.lvl   = '0;
                    d.wr_ok = 1'b1;
                    d.nx    = 1'b0;
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!e_pres) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                        d.code  = FLT_ABSENT;
                        d.flvl  = q.lvl;
                        d.pa    = '0;
                    end else if (e_leaf) begin
                        d.st   = ST_DONE;
                        d.flvl = q.lvl;
                        if (q.acc == ACC_WRITE && !wr_path) begin
                            d.fault = 1'b1;
                            d.code  = FLT_WRPROT;
                            d.pa    = '0;
                        end else if (q.acc == ACC_FETCH && nx_path) begin
                            d.fault = 1'b1;
                            d.code  = FLT_NOEXEC;
                            d.pa    = '0;
                        end else begin
                            d.fault = 1'b0;
                            d.code  = FLT_NONE;
                            d.pa    = leaf_pa;
                        end
                    end else begin
                        d.st    = ST_ISSUE;
                        d.lvl   = q.lvl + 1'b1;
                        d.base  = e_next;
                        d.wr_ok = wr_path;
                        d.nx    = nx_path;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign busy          = (q.st != ST_IDLE);
    assign mem_req_valid = (q.st == ST_ISSUE);
    assign done          = (q.st == ST_DONE);
    assign fault         = q.fault;
    assign fault_code    = q.code;
    assign fault_level   = q.flvl;
    assign paddr         = q.pa;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_one_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !done));
    p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (paddr[PG_SH-1:0] == q.va[PG_SH-1:0]));
    p_narrow_pa_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && !q.ext) |-> (paddr[PA_W-1:32] == 4'h0));
    p_code_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code != FLT_NONE));
    p_lvl_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && !q.ext) |-> (fault_level <= 2'd1));
    p_no_nx_compact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !q.ext) |-> (fault_code != FLT_NOEXEC));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(paddr) && $stable(fault) && $stable(fault_code)));
endmodule

// File: tb/xlate_walker_tb.sv
module xlate_walker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [35:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        busy, mem_req_valid, done, fault;
    logic [35:0] mem_req_addr, paddr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic [1:0]  fault_code, fault_level;

    int tests = 0;
    int fails = 0;
    int rsp_delay = 0;
    int nrd = 0;

    logic [63:0] mem [logic [35:0]];
    logic [35:0] rd_log [0:15];
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [35:0] addr_l = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_walker dut_i (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .root_base(root_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .fault_code(fault_code),
        .fault_level(fault_level), .paddr(paddr)
    );

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid) begin
            pend   <= 1'b1;
            cnt    <= rsp_delay;
            addr_l <= mem_req_addr;
            rd_log[nrd % 16] <= mem_req_addr;
            nrd    <= nrd + 1;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(addr_l) ? mem[addr_l] : 64'h0;
                pend          <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic walk(input logic ext, input logic [35:0] root, input logic [31:0] va,
                        input logic [1:0] acc, output int reads, output int start);
        @(negedge clk);
        start     = nrd;
        ext_mode  = ext;
        root_base = root;
        req_vaddr = va;
        req_acc   = acc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 500 && !done; n++) @(negedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 walk never finished got=0 exp=1");
        end
        reads = nrd - start;
    endtask

    // Table entry addresses computed from the formulas in the requirements
    function automatic logic [35:0] c0(input logic [35:0] r, input logic [31:0] v);
        return {r[35:12], v[31:22], 2'b00};
    endfunction
    function automatic logic [35:0] c1(input logic [63:0] e, input logic [31:0] v);
        return {e[31:12], v[21:12], 2'b00};
    endfunction
    function automatic logic [35:0] w0(input logic [35:0] r, input logic [31:0] v);
        return {r[35:5], v[31:30], 3'b000};
    endfunction
    function automatic logic [35:0] w1(input logic [63:0] e, input logic [31:0] v);
        return {e[35:12], v[29:21], 3'b000};
    endfunction
    function automatic logic [35:0] w2(input logic [63:0] e, input logic [31:0] v);
        return {e[35:12], v[20:12], 3'b000};
    endfunction

    localparam logic [35:0] CROOT = 36'h0_0010_0000;
    localparam logic [35:0] WROOT = 36'h8_0000_0040;

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 fault", fault, 0);
        chk("R1 mem_req_valid", mem_req_valid, 0);
        chk("R1 paddr", paddr, 0);
    endtask

    task automatic t_compact_4k();
        logic [31:0] va = 32'h0123_4567;
        logic [63:0] e0 = 64'hFFFF_FFFF_0020_0003;
        logic [63:0] e1 = 64'h8000_0000_0ABC_D003;
        int r, s;
        mem.delete();
        mem[c0(CROOT, va)] = e0;
        mem[c1(e0, va)]    = e1;
        rsp_delay = 0;
        walk(1'b0, CROOT, va, 2'd0, r, s);
        chk("R2 reads", r, 2);
        chk("R2 first addr", rd_log[s % 16], c0(CROOT, va));
        chk("R2 second addr", rd_log[(s + 1) % 16], c1(e0, va));
        chk("R2 paddr", paddr, {4'h0, e1[31:12], va[11:0]});
        chk("R2 fault", fault, 0);
        // R8: compact fetch ignores bit 63 set in both entries
        walk(1'b0, CROOT, va, 2'd2, r, s);
        chk("R8 compact fetch fault", fault, 0);
        chk("R8 compact fetch paddr", paddr, {4'h0, e1[31:12], va[11:0]});
    endtask

    task automatic t_compact_4m();
        logic [31:0] va = 32'hFFC1_2345;
        logic [63:0] e0 = 64'h0000_0000_12C0_0083;
        int r, s;
        mem.delete();
        mem[c0(CROOT, va)] = e0;
        walk(1'b0, CROOT, va, 2'd1, r, s);
        chk("R3 reads", r, 1);
        chk("R3 paddr", paddr, {4'h0, e0[31:22], va[21:0]});
        chk("R3 fault", fault, 0);
    endtask

    task automatic t_wide_4k();
        logic [31:0] va = 32'hC0A1_B2C3;
        logic [63:0] e0 = 64'h0000_0009_0000_0081;
        logic [63:0] e1 = 64'h0000_0007_1234_5003;
        logic [63:0] e2 = 64'h0000_000F_EDCB_A001;
        int r, s;
        mem.delete();
        mem[w0(WROOT, va)] = e0;
        mem[w1(e0, va)]    = e1;
        mem[w2(e1, va)]    = e2;
        rsp_delay = 3;
        walk(1'b1, WROOT, va, 2'd0, r, s);
        chk("R4 reads", r, 3);
        chk("R4 addr0", rd_log[s % 16], w0(WROOT, va));
        chk("R4 addr1", rd_log[(s + 1) % 16], w1(e0, va));
        chk("R4 addr2", rd_log[(s + 2) % 16], w2(e1, va));
        chk("R4 paddr", paddr, {e2[35:12], va[11:0]});
        chk("R4 fault", fault, 0);
        rsp_delay = 0;
    endtask

    task automatic t_wide_2m();
        logic [31:0] va = 32'h5F3A_7777;
        logic [63:0] e0 = 64'h0000_0003_0000_0003;
        logic [63:0] e1 = 64'h0000_0005_5560_0083;
        int r, s;
        mem.delete();
        mem[w0(WROOT, va)] = e0;
        mem[w1(e0, va)]    = e1;
        walk(1'b1, WROOT, va, 2'd1, r, s);
        chk("R5 reads", r, 2);
        chk("R5 paddr", paddr, {e1[35:21], va[20:0]});
        chk("R5 fault", fault, 0);
    endtask

    task automatic t_absent();
        logic [31:0] va = 32'h0040_3000;
        logic [63:0] e0 = 64'h0000_0000_0030_0003;
        int r, s;
        mem.delete();
        mem[c0(CROOT, va)] = e0;
        walk(1'b0, CROOT, va, 2'd0, r, s);
        chk("R6 compact fault", fault, 1);
        chk("R6 compact code", fault_code, 1);
        chk("R6 compact level", fault_level, 1);
        chk("R6 compact reads", r, 2);
        mem.delete();
        walk(1'b1, WROOT, va, 2'd0, r, s);
        chk("R6 wide code", fault_code, 1);
        chk("R6 wide level", fault_level, 0);
        chk("R6 wide reads", r, 1);
    endtask

    task automatic t_wrprot();
        logic [31:0] va = 32'h0081_2ABC;
        logic [63:0] e0 = 64'h0000_0000_0040_0001;
        logic [63:0] e1 = 64'h0000_0000_0BEE_F003;
        int r, s;
        mem.delete();
        mem[c0(CROOT, va)] = e0;
        mem[c1(e0, va)]    = e1;
        walk(1'b0, CROOT, va, 2'd1, r, s);
        chk("R7 write fault", fault, 1);
        chk("R7 write code", fault_code, 2);
        chk("R7 write level", fault_level, 1);
        walk(1'b0, CROOT, va, 2'd0, r, s);
        chk("R7 read fault", fault, 0);
        chk("R7 read paddr", paddr, {4'h0, e1[31:12], va[11:0]});
    endtask

    task automatic t_noexec();
        logic [31:0] va = 32'h4123_4FED;
        logic [63:0] e0 = 64'h0000_0002_0000_0003;
        logic [63:0] e1 = 64'h8000_0006_0000_0003;
        logic [63:0] e2 = 64'h0000_0001_2345_6003;
        int r, s;
        mem.delete();
        mem[w0(WROOT, va)] = e0;
        mem[w1(e0, va)]    = e1;
        mem[w2(e1, va)]    = e2;
        walk(1'b1, WROOT, va, 2'd2, r, s);
        chk("R8 fetch fault", fault, 1);
        chk("R8 fetch code", fault_code, 3);
        chk("R8 fetch level", fault_level, 2);
        walk(1'b1, WROOT, va, 2'd0, r, s);
        chk("R8 read fault", fault, 0);
        chk("R8 read paddr", paddr, {e2[35:12], va[11:0]});
    endtask

    task automatic t_busy();
        logic [31:0] va = 32'h8765_4321;
        logic [63:0] e0 = 64'h0000_000A_0000_0003;
        logic [63:0] e1 = 64'h0000_000B_0000_0003;
        logic [63:0] e2 = 64'h0000_000C_DEF0_1003;
        logic [35:0] held;
        int s;
        mem.delete();
        mem[w0(WROOT, va)] = e0;
        mem[w1(e0, va)]    = e1;
        mem[w2(e1, va)]    = e2;
        rsp_delay = 6;
        @(negedge clk);
        s = nrd;
        ext_mode = 1'b1; root_base = WROOT; req_vaddr = va; req_acc = 2'd0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after accept", busy, 1);
        repeat (3) @(negedge clk);
        ext_mode = 1'b0; root_base = CROOT; req_vaddr = 32'h0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 still busy", busy, 1);
        for (int n = 0; n < 500 && !done; n++) @(negedge clk);
        chk("R9 done seen", done, 1);
        chk("R9 result of first walk", paddr, {e2[35:12], va[11:0]});
        chk("R9 reads of first walk", nrd - s, 3);
        held = paddr;
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R9 idle after done", busy, 0);
        repeat (5) @(negedge clk);
        chk("R9 no extra read", nrd - s, 3);
        chk("R10 paddr held", paddr, held);
        chk("R10 fault held", fault, 0);
        rsp_delay = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_compact_4k();
        t_compact_4m();
        t_wide_4k();
        t_wide_2m();
        t_absent();
        t_wrprot();
        t_noexec();
        t_busy();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL R9 watchdog expired got=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule